// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Block

This block is the software-facing register window of one channel in a descriptor-driven DMA controller. A host issues 32-bit reads and writes with an offset inside the channel's 8 KiB window. The surrounding fabric picks the channel from the offset's upper bits (offset shifted right by 13), so this block only sees the low 13 bits. It holds the descriptor pointers, the configuration and interrupt-mask registers, a small one-hot channel state machine (reset, stopped, running) and the end-of-list flag. It returns a composed status word.

The block does not move data and does not fetch descriptors. A separate transfer engine does that work. This block sends the engine single-cycle request pulses: load a data descriptor, load a context descriptor, start, reload the current descriptor, and advance to the next descriptor. The engine returns raw interrupt-set pulses, a list-end pulse, the end-of-list bit of its current descriptor, and a reload-complete pulse.

The interrupt output is the OR of the raw interrupt bits gated by the mask. Software clears raw bits through a write-one-to-clear acknowledge register that always reads as zero. A continue command restarts a channel that stalled at the end of its list, but only after software has cleared that descriptor's end-of-list bit.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset every register reads zero, the status word reads 0x001 (state reset, end-of-list clear) and `irq_o` is low; the state is always exactly one of reset=1, stopped=2, running=4.
- R2: Word writes to the pointer registers at offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C store the full 32-bit value, which reads back unchanged and drives the matching pointer output.
- R3: A request with `req_size_i` other than 2 (0 = byte, 1 = halfword, 2 = word) gets `rsp_err_o` high in its response cycle and modifies no register; word requests get no error.
- R4: A word write to config (0x84) stores bits [1:0] (bit 0 enable, bit 1 stop) and updates the state: bit 1 set forces stopped, and bit 0 clear forces reset, taking priority over the stop. With bit 0 set and bit 1 clear, the state is unchanged.
- R5: The status word (0x88) carries the state in bits [2:0], the end-of-list flag at bit 5, `eng_stream_src_i` at bit 8 and zero elsewhere. A pulse on `eng_list_end_i` sets the end-of-list flag.
- R6: A stream-command write (0x9C) uses only bits [9:0]. Any of bits 8 or 6 (mask 0x140) pulses `eng_ld_data_o`, and with bit 5 (0x20) also a start. Bit 9 (0x200) pulses `eng_ld_ctx_o` and a start. A start pulses `eng_start_o`, sets the state to running and clears the end-of-list flag.
- R7: A pulse on bit i of `eng_irq_set_i` sets raw interrupt bit i (read at 0x94). A word write to acknowledge (0x90) clears the raw bits written as one, and a set in the same cycle wins. The acknowledge register always reads zero.
- R8: The mask (0x8C) keeps its low NIRQ=4 bits. The masked interrupt read (0x98) equals raw AND mask, and `irq_o` is high exactly when that value is nonzero.
- R9: A word write to command (0x80) pulses `eng_reload_o` only when config bit 0 is set, config bit 1 is clear, the state is running and `eng_desc_eol_i` is high; otherwise no reload is requested.
- R10: On the `eng_reload_done_i` pulse that answers a pending reload, if `eng_desc_eol_i` is now low and the end-of-list flag is set, the block pulses `eng_advance_o` together with a start. Otherwise nothing changes.
- R11: Reads of unmapped offsets return zero without error, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte offset inside the channel window |
| req_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Error response for non-word access |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Channel interrupt line |
| ptr_data_o | output | 32 | Current data descriptor pointer |
| ptr_saved_o | output | 32 | Saved data descriptor pointer |
| ptr_buf_o | output | 32 | Saved data buffer pointer |
| ptr_group_o | output | 32 | Group descriptor pointer |
| ptr_gdown_o | output | 32 | Group-down (context) pointer |
| eng_ld_data_o | output | 1 | Request: load data descriptor |
| eng_ld_ctx_o | output | 1 | Request: load context descriptor |
| eng_start_o | output | 1 | Request: start transfer |
| eng_reload_o | output | 1 | Request: reload current descriptor |
| eng_advance_o | output | 1 | Request: step to next descriptor |
| eng_irq_set_i | input | 4 | Raw interrupt set pulses |
| eng_list_end_i | input | 1 | Engine reached end of list |
| eng_desc_eol_i | input | 1 | End-of-list bit of the current descriptor |
| eng_reload_done_i | input | 1 | Reload finished |
| eng_stream_src_i | input | 1 | Stream-command source indication |

## Verification
The hardest state to reach is the successful continue. The channel must be enabled, running and flagged at end of list, and the engine's descriptor bit must be high when the command arrives and low when the reload completes. The bench gets there step by step. It writes the config, starts the channel with a context-load stream command and pulses the list-end input. It then issues the command with the descriptor bit high and answers the reload first with the bit still set (no advance) and then with it cleared (advance plus restart). Further stimulus covers the negative cases for a low descriptor bit and a stopped channel, and a raw interrupt set that coincides with its own acknowledge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } chan_state_e;

  localparam int unsigned OFF_DPTR   = 'h000;
  localparam int unsigned OFF_SDATA  = 'h058;
  localparam int unsigned OFF_SBUF   = 'h05C;
  localparam int unsigned OFF_GRP    = 'h060;
  localparam int unsigned OFF_GDOWN  = 'h07C;
  localparam int unsigned OFF_CMD    = 'h080;
  localparam int unsigned OFF_CFG    = 'h084;
  localparam int unsigned OFF_STAT   = 'h088;
  localparam int unsigned OFF_MASK   = 'h08C;
  localparam int unsigned OFF_ACK    = 'h090;
  localparam int unsigned OFF_RAW    = 'h094;
  localparam int unsigned OFF_MASKED = 'h098;
  localparam int unsigned OFF_SCMD   = 'h09C;

  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int unsigned SCMD_W = 10;
  localparam logic [SCMD_W-1:0] SC_LOAD_DATA = 10'h140;
  localparam logic [SCMD_W-1:0] SC_BURST     = 10'h020;
  localparam logic [SCMD_W-1:0] SC_LOAD_CTX  = 10'h200;

  localparam int unsigned STAT_EOL_BIT = 5;
  localparam int unsigned STAT_SRC_BIT = 8;

  typedef struct packed {
    logic dptr;
    logic sdata;
    logic sbuf;
    logic grp;
    logic gdown;
    logic cmd;
    logic cfg;
    logic stat;
    logic mask;
    logic ack;
    logic raw;
    logic masked;
    logic scmd;
  } reg_hit_t;

endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_hit_t          wr_hit,
  output reg_hit_t          rd_hit,
  output logic              bad_size
);

  reg_hit_t hit;
  logic     word;

  always_comb begin
    hit = '0;
    case (req_addr)
      ADDR_W'(OFF_DPTR):   hit.dptr   = 1'b1;
      ADDR_W'(OFF_SDATA):  hit.sdata  = 1'b1;
      ADDR_W'(OFF_SBUF):   hit.sbuf   = 1'b1;
      ADDR_W'(OFF_GRP):    hit.grp    = 1'b1;
      ADDR_W'(OFF_GDOWN):  hit.gdown  = 1'b1;
      ADDR_W'(OFF_CMD):    hit.cmd    = 1'b1;
      ADDR_W'(OFF_CFG):    hit.cfg    = 1'b1;
      ADDR_W'(OFF_STAT):   hit.stat   = 1'b1;
      ADDR_W'(OFF_MASK):   hit.mask   = 1'b1;
      ADDR_W'(OFF_ACK):    hit.ack    = 1'b1;
      ADDR_W'(OFF_RAW):    hit.raw    = 1'b1;
      ADDR_W'(OFF_MASKED): hit.masked = 1'b1;
      ADDR_W'(OFF_SCMD):   hit.scmd   = 1'b1;
      default:             hit        = '0;
    endcase
  end

  assign word     = (req_size == SZ_WORD);
  assign bad_size = req_valid && !word;
  assign wr_hit   = (req_valid && req_write && word) ? hit : '0;
  assign rd_hit   = (req_valid && !req_write && word) ? hit : '0;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_wval,
  input  logic [1:0]        cfg_q,
  input  logic              scmd_wr,
  input  logic [SCMD_W-1:0] scmd_val,
  input  logic              cmd_wr,
  input  logic              list_end,
  input  logic              desc_eol,
  input  logic              reload_done,
  output chan_state_e       state_q,
  output logic              eol_q,
  output logic              ld_data_o,
  output logic              ld_ctx_o,
  output logic              start_o,
  output logic              reload_o,
  output logic              advance_o
);

  chan_state_e state_d;
  logic eol_d, pend_q, pend_d;
  logic ld_data_d, ld_ctx_d, start_d, reload_d, advance_d;

  always_comb begin
    state_d   = state_q;
    eol_d     = eol_q;
    pend_d    = pend_q;
    ld_data_d = 1'b0;
    ld_ctx_d  = 1'b0;
    start_d   = 1'b0;
    reload_d  = 1'b0;
    advance_d = 1'b0;

    if (list_end) eol_d = 1'b1;

    if (cfg_wr) begin
      if (cfg_wval[1])  state_d = ST_STOP;
      if (!cfg_wval[0]) state_d = ST_RST;
    end

    if (scmd_wr) begin
      if (|(scmd_val & SC_LOAD_DATA)) begin
        ld_data_d = 1'b1;
        if (|(scmd_val & SC_BURST)) start_d = 1'b1;
      end
      if (|(scmd_val & SC_LOAD_CTX)) begin
        ld_ctx_d = 1'b1;
        start_d  = 1'b1;
      end
    end

    if (pend_q && reload_done) begin
      pend_d = 1'b0;
      if (!desc_eol && eol_q) begin
        advance_d = 1'b1;
        start_d   = 1'b1;
      end
    end

    if (cmd_wr && cfg_q[0] && !cfg_q[1] && state_q == ST_RUN && desc_eol) begin
      reload_d = 1'b1;
      pend_d   = 1'b1;
    end

    if (start_d) begin
      eol_d   = 1'b0;
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RST;
      eol_q     <= 1'b0;
      pend_q    <= 1'b0;
      ld_data_o <= 1'b0;
      ld_ctx_o  <= 1'b0;
      start_o   <= 1'b0;
      reload_o  <= 1'b0;
      advance_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      eol_q     <= eol_d;
      pend_q    <= pend_d;
      ld_data_o <= ld_data_d;
      ld_ctx_o  <= ld_ctx_d;
      start_o   <= start_d;
      reload_o  <= reload_d;
      advance_o <= advance_d;
    end
  end

endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] set_i,
  input  logic            ack_wr,
  input  logic            mask_wr,
  input  logic [NIRQ-1:0] wval,
  output logic [NIRQ-1:0] raw_q,
  output logic [NIRQ-1:0] mask_q,
  output logic            irq_o
);

  logic [NIRQ-1:0] raw_d, mask_d;

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    assign raw_d[i] = set_i[i] | (raw_q[i] & ~(ack_wr & wval[i]));
  end

  assign mask_d = mask_wr ? wval : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_o  <= |(raw_d & mask_d);
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] ptr_data_o,
  output logic [DATA_W-1:0] ptr_saved_o,
  output logic [DATA_W-1:0] ptr_buf_o,
  output logic [DATA_W-1:0] ptr_group_o,
  output logic [DATA_W-1:0] ptr_gdown_o,
  output logic              eng_ld_data_o,
  output logic              eng_ld_ctx_o,
  output logic              eng_start_o,
  output logic              eng_reload_o,
  output logic              eng_advance_o,
  input  logic [NIRQ-1:0]   eng_irq_set_i,
  input  logic              eng_list_end_i,
  input  logic              eng_desc_eol_i,
  input  logic              eng_reload_done_i,
  input  logic              eng_stream_src_i
);

  localparam int PTR_N = 5;

  reg_hit_t        wr_hit, rd_hit;
  logic            bad_size;
  logic [DATA_W-1:0] ptr_q [PTR_N];
  logic [PTR_N-1:0]  ptr_wr, ptr_rd;
  logic [1:0]        cfg_q;
  logic              cmd_q;
  logic [SCMD_W-1:0] scmd_q;
  chan_state_e       state_w;
  logic              eol_w;
  logic [NIRQ-1:0]   raw_w, mask_w;
  logic [DATA_W-1:0] rd_mux, stat_word;

  dma_chan_decode #(.ADDR_W(ADDR_W)) dec_i (
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .req_addr  (req_addr_i),
    .req_size  (req_size_i),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .bad_size  (bad_size)
  );

  assign ptr_wr = {wr_hit.gdown, wr_hit.grp, wr_hit.sbuf, wr_hit.sdata, wr_hit.dptr};
  assign ptr_rd = {rd_hit.gdown, rd_hit.grp, rd_hit.sbuf, rd_hit.sdata, rd_hit.dptr};

  for (genvar i = 0; i < PTR_N; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)            ptr_q[i] <= '0;
      else if (ptr_wr[i]) ptr_q[i] <= req_wdata_i;
    end
  end

  assign ptr_data_o  = ptr_q[0];
  assign ptr_saved_o = ptr_q[1];
  assign ptr_buf_o   = ptr_q[2];
  assign ptr_group_o = ptr_q[3];
  assign ptr_gdown_o = ptr_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      cmd_q  <= 1'b0;
      scmd_q <= '0;
    end else begin
      if (wr_hit.cfg)  cfg_q  <= req_wdata_i[1:0];
      if (wr_hit.cmd)  cmd_q  <= req_wdata_i[0];
      if (wr_hit.scmd) scmd_q <= req_wdata_i[SCMD_W-1:0];
    end
  end

  dma_chan_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (wr_hit.cfg),
    .cfg_wval    (req_wdata_i[1:0]),
    .cfg_q       (cfg_q),
    .scmd_wr     (wr_hit.scmd),
    .scmd_val    (req_wdata_i[SCMD_W-1:0]),
    .cmd_wr      (wr_hit.cmd),
    .list_end    (eng_list_end_i),
    .desc_eol    (eng_desc_eol_i),
    .reload_done (eng_reload_done_i),
    .state_q     (state_w),
    .eol_q       (eol_w),
    .ld_data_o   (eng_ld_data_o),
    .ld_ctx_o    (eng_ld_ctx_o),
    .start_o     (eng_start_o),
    .reload_o    (eng_reload_o),
    .advance_o   (eng_advance_o)
  );

  dma_chan_irq #(.NIRQ(NIRQ)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .set_i   (eng_irq_set_i),
    .ack_wr  (wr_hit.ack),
    .mask_wr (wr_hit.mask),
    .wval    (req_wdata_i[NIRQ-1:0]),
    .raw_q   (raw_w),
    .mask_q  (mask_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    stat_word = '0;
    stat_word[2:0] = state_w;
    stat_word[STAT_EOL_BIT] = eol_w;
    stat_word[STAT_SRC_BIT] = eng_stream_src_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < PTR_N; i++) begin
      if (ptr_rd[i]) rd_mux = rd_mux | ptr_q[i];
    end
    if (rd_hit.cmd)    rd_mux = rd_mux | DATA_W'(cmd_q);
    if (rd_hit.cfg)    rd_mux = rd_mux | DATA_W'(cfg_q);
    if (rd_hit.stat)   rd_mux = rd_mux | stat_word;
    if (rd_hit.mask)   rd_mux = rd_mux | DATA_W'(mask_w);
    if (rd_hit.raw)    rd_mux = rd_mux | DATA_W'(raw_w);
    if (rd_hit.masked) rd_mux = rd_mux | DATA_W'(raw_w & mask_w);
    if (rd_hit.scmd)   rd_mux = rd_mux | DATA_W'(scmd_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= bad_size;
      rsp_rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NIRQ   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_err_o,
  input logic              irq_o,
  input logic              eng_start_o,
  input logic              eng_reload_o,
  input logic              eng_advance_o,
  input chan_state_e       state_w,
  input logic              eol_w,
  input logic [NIRQ-1:0]   raw_w,
  input logic [NIRQ-1:0]   mask_w
);

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_w) == 1);

  // R3
  size_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_size_i != SZ_WORD) |=> rsp_err_o);

  // R3
  word_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_size_i == SZ_WORD) |=> !rsp_err_o);

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw_w & mask_w));

  // R9
  reload_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eng_reload_o |-> $past(req_valid_i && req_write_i && req_size_i == SZ_WORD
                           && req_addr_i == ADDR_W'(OFF_CMD)));

  // R6
  start_state_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |-> (state_w == ST_RUN && !eol_w));

  // R10
  advance_start_chk: assert property (@(posedge clk) disable iff (rst)
    eng_advance_o |-> eng_start_o);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .NIRQ(NIRQ)) chk_i (.*);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, irq;
  logic [31:0] rsp_rdata;
  logic [31:0] p_data, p_saved, p_buf, p_group, p_gdown;
  logic        ld_data, ld_ctx, start, reload, advance;
  logic [3:0]  irq_set = '0;
  logic        list_end = 1'b0, desc_eol = 1'b0, reload_done = 1'b0, stream_src = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic s_ld_data, s_ld_ctx, s_start, s_reload, s_advance, s_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq),
    .ptr_data_o(p_data), .ptr_saved_o(p_saved), .ptr_buf_o(p_buf),
    .ptr_group_o(p_group), .ptr_gdown_o(p_gdown),
    .eng_ld_data_o(ld_data), .eng_ld_ctx_o(ld_ctx), .eng_start_o(start),
    .eng_reload_o(reload), .eng_advance_o(advance),
    .eng_irq_set_i(irq_set), .eng_list_end_i(list_end),
    .eng_desc_eol_i(desc_eol), .eng_reload_done_i(reload_done),
    .eng_stream_src_i(stream_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_ld_data = ld_data; s_ld_ctx = ld_ctx; s_start = start;
    s_reload = reload; s_advance = advance; s_err = rsp_err;
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
    snap();
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; s_err = rsp_err;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq), 32'd0);
    bus_rd(13'h088, d); check("R1 status after reset", d, 32'h001);
    bus_rd(13'h000, d); check("R1 data ptr after reset", d, 32'h0);
    bus_rd(13'h084, d); check("R1 config after reset", d, 32'h0);
  endtask

  task automatic t_pointers();
    logic [31:0] d;
    bus_wr(13'h000, 32'hA5A5_0001); bus_wr(13'h058, 32'h1234_5678);
    bus_wr(13'h05C, 32'hDEAD_BEEF); bus_wr(13'h060, 32'h0F0F_F0F0);
    bus_wr(13'h07C, 32'h8000_0004);
    bus_rd(13'h000, d); check("R2 data ptr", d, 32'hA5A5_0001);
    bus_rd(13'h058, d); check("R2 saved ptr", d, 32'h1234_5678);
    bus_rd(13'h05C, d); check("R2 buf ptr", d, 32'hDEAD_BEEF);
    bus_rd(13'h060, d); check("R2 group ptr", d, 32'h0F0F_F0F0);
    bus_rd(13'h07C, d); check("R2 gdown ptr", d, 32'h8000_0004);
    check("R2 buf ptr output", p_buf, 32'hDEAD_BEEF);
    check("R2 gdown ptr output", p_gdown, 32'h8000_0004);
  endtask

  task automatic t_size_err();
    logic [31:0] d;
    bus_wr(13'h000, 32'h0000_0077, 2'd1); check("R3 halfword error", 32'(s_err), 32'd1);
    bus_wr(13'h000, 32'h0000_0066, 2'd0); check("R3 byte error", 32'(s_err), 32'd1);
    bus_rd(13'h000, d); check("R3 word read no error", 32'(s_err), 32'd0);
    check("R3 data ptr unchanged", d, 32'hA5A5_0001);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_wr(13'h084, 32'h3); bus_rd(13'h088, d); check("R4 stop bit gives stopped", d, 32'h002);
    bus_wr(13'h084, 32'h2); bus_rd(13'h088, d); check("R4 enable clear wins", d, 32'h001);
    bus_wr(13'h084, 32'h1); bus_rd(13'h088, d); check("R4 enable only keeps state", d, 32'h001);
    bus_rd(13'h084, d); check("R4 config readback", d, 32'h1);
  endtask

  task automatic t_stream();
    logic [31:0] d;
    bus_wr(13'h09C, 32'h140);
    check("R6 load data pulse", 32'(s_ld_data), 32'd1);
    check("R6 no start without burst", 32'(s_start), 32'd0);
    bus_rd(13'h088, d); check("R6 state unchanged", d, 32'h001);
    bus_wr(13'h09C, 32'h400);
    check("R6 bit 10 ignored", 32'({s_ld_data, s_ld_ctx, s_start}), 32'd0);
    bus_wr(13'h09C, 32'h060);
    check("R6 load data plus burst", 32'({s_ld_data, s_start}), 32'h3);
    bus_rd(13'h088, d); check("R6 running after burst", d, 32'h004);
    bus_wr(13'h084, 32'h0);
    @(negedge clk); list_end = 1'b1; @(negedge clk); list_end = 1'b0;
    stream_src = 1'b1;
    bus_rd(13'h088, d); check("R5 status eol and source", d, 32'h121);
    stream_src = 1'b0;
    bus_wr(13'h09C, 32'h200);
    check("R6 context load and start", 32'({s_ld_ctx, s_start, s_ld_data}), 32'h6);
    bus_rd(13'h088, d); check("R6 start clears eol", d, 32'h004);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    @(negedge clk); irq_set = 4'b0101; @(negedge clk); irq_set = '0;
    bus_rd(13'h094, d); check("R7 raw set", d, 32'h5);
    check("R8 irq low with mask zero", 32'(irq), 32'd0);
    bus_wr(13'h08C, 32'hFFFF_FFF4);
    bus_rd(13'h08C, d); check("R8 mask keeps low bits", d, 32'h4);
    bus_rd(13'h098, d); check("R8 masked value", d, 32'h4);
    check("R8 irq high", 32'(irq), 32'd1);
    bus_wr(13'h090, 32'h4);
    bus_rd(13'h094, d); check("R7 ack clears bit", d, 32'h1);
    check("R8 irq low after ack", 32'(irq), 32'd0);
    bus_rd(13'h090, d); check("R7 ack reads zero", d, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h090; req_wdata = 32'h3; irq_set = 4'b0001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_set = '0;
    bus_rd(13'h094, d); check("R7 set wins over ack", d, 32'h1);
  endtask

  task automatic t_continue();
    logic [31:0] d;
    bus_wr(13'h084, 32'h1);
    bus_wr(13'h09C, 32'h200);
    @(negedge clk); list_end = 1'b1; @(negedge clk); list_end = 1'b0;
    desc_eol = 1'b0;
    bus_wr(13'h080, 32'h1); check("R9 no reload when desc eol low", 32'(s_reload), 32'd0);
    desc_eol = 1'b1;
    bus_wr(13'h080, 32'h1); check("R9 reload requested", 32'(s_reload), 32'd1);
    @(negedge clk); reload_done = 1'b1; @(negedge clk); reload_done = 1'b0; snap();
    check("R10 no advance while desc eol set", 32'({s_advance, s_start}), 32'd0);
    bus_rd(13'h088, d); check("R10 status still at eol", d, 32'h024);
    bus_wr(13'h080, 32'h1); check("R9 second reload", 32'(s_reload), 32'd1);
    desc_eol = 1'b0;
    @(negedge clk); reload_done = 1'b1; @(negedge clk); reload_done = 1'b0; snap();
    check("R10 advance and start", 32'({s_advance, s_start}), 32'h3);
    bus_rd(13'h088, d); check("R10 running with eol clear", d, 32'h004);
    desc_eol = 1'b1;
    bus_wr(13'h084, 32'h3);
    bus_wr(13'h080, 32'h1); check("R9 no reload when stopped", 32'(s_reload), 32'd0);
    desc_eol = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(13'h004, 32'hFFFF_FFFF);
    check("R11 unmapped write no error", 32'(s_err), 32'd0);
    bus_rd(13'h004, d); check("R11 unmapped read zero", d, 32'h0);
    bus_rd(13'h058, d); check("R11 saved ptr untouched", d, 32'h1234_5678);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointers();
    t_size_err();
    t_config();
    t_stream();
    t_irq();
    t_continue();
    t_unmapped();
    finish_run();
  end

endmodule